// File: doc/BRIEF.md
# UART Input Channel Dispatcher

The dispatcher sits behind a single UART receiver and fans its byte stream out to eight independent device queues: one for panel switches, one for the console keyboard, one for the card reader and so on. A single writer means no arbitration and no shared queue. Every received byte lands in exactly one place, and each consumer drains its own queue at its own pace.

A light in-band framing picks the destination. A byte with its top bit set and bits 6:3 all zero is a steering byte. Its low three bits name the channel, and it is never stored. Every other byte is payload for whichever channel was steered to last. The selection holds until the next steering byte arrives, and reset selects channel 0. Each channel has a write strobe that pulses when one of its bytes is stored. Each channel also has a sticky overflow flag that records a byte lost to a full queue.

The input side is a valid/ready stream whose ready is held high, so the UART is never stalled. A byte that finds its queue full is discarded and flagged, not held back. Each output side is a valid/ready stream: valid means the queue is non-empty and the data is the oldest entry, and one entry leaves on every clock in which valid and ready are both high.

Top module: `uart_chan_dispatch`

## Requirements
- R1: After synchronous active-low reset all queues are empty (`out_valid` all 0), all overflow flags are 0, and channel 0 is selected, so the first payload byte goes to channel 0.
- R2: A byte with bit 7 = 1 and bits 6:3 = 0 is a steering byte: bits 2:0 become the selected channel. It is stored nowhere and raises no write strobe.
- R3: Any other byte, including bytes with bit 7 set and a non-zero value in bits 6:3, is payload for the selected channel only. The selection persists across any number of payload bytes.
- R4: `wr_strobe[i]` is high during the same cycle in which an accepted payload byte is stored into channel i. All other strobe bits are low in that cycle, and all bits are low when nothing is stored.
- R5: `in_ready` is always 1; no input byte is ever stalled.
- R6: `out_valid[i]` is 1 exactly when queue i holds data, and `out_data` lane i (bits 8i+7:8i) then shows its oldest byte. One entry is removed per clock with `out_valid[i]` and `out_ready[i]` both high. `out_ready[i]` on an empty queue has no effect.
- R7: Each queue returns bytes in arrival order and holds 16 entries.
- R8: A payload byte aimed at a full queue is dropped. It raises no strobe, leaves the queue contents unchanged, and sets `overflow[i]`. The flag stays set, even after draining, until reset.
- R9: Queues are independent: a pop or write on one channel leaves every other channel's valid, data and overflow unchanged.
- R10: When a queue is full, a payload byte arriving in the same cycle as a pop from that queue is still dropped (the full test uses the fill level before the pop).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Always 1; dispatcher never stalls |
| wr_strobe | output | 8 | Per-channel stored-byte pulse |
| out_valid | output | 8 | Per-channel queue non-empty |
| out_data | output | 64 | Per-channel head byte, lane i at bits 8i+7:8i |
| out_ready | input | 8 | Per-channel pop request |
| overflow | output | 8 | Per-channel sticky dropped-byte flag |

## Verification
The bench builds the block with its defaults: eight channels and sixteen-entry queues. These values make every steering code and a full queue reachable within a few dozen bytes. Filling channel 2 past its sixteenth entry exercises the drop, the sticky flag and the pop-on-full collision without long runs. Bytes in the 0x88–0xFF range confirm that only the exact steering pattern changes the selection.

// File: rtl/uart_dispatch_pkg.sv
package uart_dispatch_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/uart_dispatch_fifo.sv
module uart_dispatch_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ack,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     level;
  logic              full, push, pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full     = (level == FULL_LVL);
  assign rd_valid = (level != '0);
  assign push     = wr_req && !full;
  assign pop      = rd_ready && rd_valid;
  assign wr_ack   = push;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (wr_req && full) overflow <= 1'b1;
    end
  end

  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);
  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_full_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full) |=> overflow);
  p_empty_pop_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid && !wr_req) |=> (level == '0));
  p_full_collision_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full && rd_ready) |=> (level == FULL_LVL - 1'b1));
endmodule

// File: rtl/uart_dispatch_decode.sv
module uart_dispatch_decode
  import uart_dispatch_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  byte_t             in_data,
  output logic [NUM_CH-1:0] wr_req
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [CH_W-1:0] sel_q;
  logic            steer;

  assign steer = in_data[BYTE_W-1] && (in_data[BYTE_W-2:CH_W] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                sel_q <= '0;
    else if (in_valid && steer) sel_q <= in_data[CH_W-1:0];
  end

  always_comb begin
    wr_req = '0;
    if (in_valid && !steer) wr_req[sel_q] = 1'b1;
  end

  p_one_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_req));
  p_steer_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[7] && in_data[6:3] == 4'd0) |-> (wr_req == '0));
  p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && steer) |=> $stable(sel_q));
endmodule

// File: rtl/uart_chan_dispatch.sv
module uart_chan_dispatch
  import uart_dispatch_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  output logic                     in_ready,
  output logic [NUM_CH-1:0]        wr_strobe,
  output logic [NUM_CH-1:0]        out_valid,
  output logic [NUM_CH*BYTE_W-1:0] out_data,
  input  logic [NUM_CH-1:0]        out_ready,
  output logic [NUM_CH-1:0]        overflow
);
  logic [NUM_CH-1:0] wr_req;

  assign in_ready = 1'b1;

  uart_dispatch_decode #(.NUM_CH(NUM_CH)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .wr_req   (wr_req)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    uart_dispatch_fifo #(.DATA_W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req   (wr_req[c]),
      .wr_data  (in_data),
      .wr_ack   (wr_strobe[c]),
      .rd_ready (out_ready[c]),
      .rd_valid (out_valid[c]),
      .rd_data  (out_data[c*BYTE_W +: BYTE_W]),
      .overflow (overflow[c])
    );
  end

  p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobe));
  p_strobe_needs_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe != '0) |-> in_valid);
  p_strobe_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe != '0) |=> ((out_valid & $past(wr_strobe)) == $past(wr_strobe)));
endmodule

// File: tb/uart_chan_dispatch_tb.sv
module uart_chan_dispatch_tb;
  localparam int NCH = 8;
  localparam int NV  = 12;
  localparam logic [11:0] VEC [NV] = '{
    {8'h41, 4'd0},  {8'h83, 4'd15}, {8'h10, 4'd3},  {8'hFF, 4'd3},
    {8'hC7, 4'd3},  {8'h87, 4'd15}, {8'h00, 4'd7},  {8'h80, 4'd15},
    {8'h55, 4'd0},  {8'h85, 4'd15}, {8'h86, 4'd15}, {8'h22, 4'd6}
  };

  logic clk = 0, rst_n = 0, in_valid = 0, in_ready;
  logic [7:0] in_data = 0;
  logic [NCH-1:0] wr_strobe, out_valid, out_ready = 0, overflow;
  logic [NCH*8-1:0] out_data;
  int checks = 0, errors = 0;
  int mq [NCH][16];
  int mh [NCH], mt [NCH];

  always #5 clk = ~clk;

  uart_chan_dispatch u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .wr_strobe(wr_strobe),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .overflow(overflow));

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input int exp_strobe, input string tag);
    @(negedge clk);
    in_valid = 1; in_data = b;
    #1 chk(int'(wr_strobe), exp_strobe, tag);
    chk(int'(in_ready), 1, "R5 in_ready");
    @(posedge clk); #1 in_valid = 0;
  endtask

  task automatic pop(input int ch, input int exp, input string tag);
    @(negedge clk);
    chk(int'(out_valid[ch]), 1, tag);
    chk(int'(out_data[ch*8 +: 8]), exp, tag);
    out_ready[ch] = 1;
    @(posedge clk); #1 out_ready[ch] = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (2) @(posedge clk); #1 rst_n = 1;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin mh[c] = 0; mt[c] = 0; end
    do_reset();
    @(negedge clk);
    chk(int'(out_valid), 0, "R1 empty after reset");
    chk(int'(overflow), 0, "R1 overflow clear");

    // R2 R3 R4: table walk
    for (int v = 0; v < NV; v++) begin
      int ec;
      ec = int'(VEC[v][3:0]);
      if (ec == 15) put(VEC[v][11:4], 0, "R2 steering byte silent");
      else begin
        put(VEC[v][11:4], 1 << ec, "R3/R4 payload strobe");
        mq[ec][mt[ec]] = int'(VEC[v][11:4]); mt[ec]++;
      end
    end
    @(negedge clk);
    chk(int'(out_valid), 8'b1100_1001, "R6 valid per channel");
    // R7 R9: drain in order per channel
    for (int c = 0; c < NCH; c++)
      while (mh[c] < mt[c]) begin
        pop(c, mq[c][mh[c]], "R7 order");
        mh[c]++;
      end
    @(negedge clk);
    chk(int'(out_valid), 0, "R6 all drained");

    // R6: pop on empty ignored
    out_ready = '1;
    repeat (2) @(posedge clk);
    #1 out_ready = '0;
    put(8'h81, 0, "R2 select ch1");
    put(8'h3C, 2, "R4 strobe ch1");
    @(negedge clk);
    chk(int'(out_data[15:8]), 8'h3C, "R6 empty pop ignored");

    // R9: pop ch1 while writing ch4
    put(8'h84, 0, "R2 select ch4");
    @(negedge clk);
    in_valid = 1; in_data = 8'h5A; out_ready[1] = 1;
    #1 chk(int'(wr_strobe), 16, "R9 write ch4 during pop ch1");
    @(posedge clk); #1 in_valid = 0; out_ready[1] = 0;
    @(negedge clk);
    chk(int'(out_valid[1]), 0, "R9 ch1 popped");
    chk(int'(out_data[39:32]), 8'h5A, "R9 ch4 intact");
    pop(4, 8'h5A, "R9 ch4 pop");

    // R8: overfill channel 2
    put(8'h82, 0, "R2 select ch2");
    for (int i = 0; i < 16; i++) put(8'h20 + 8'(i), 4, "R7 fill");
    put(8'h99, 0, "R8 drop on full");
    @(negedge clk);
    chk(int'(overflow), 4, "R8 overflow flag ch2 only");
    chk(int'(out_data[23:16]), 8'h20, "R8 head unchanged");
    // R10: write and pop same cycle when full
    @(negedge clk);
    in_valid = 1; in_data = 8'h77; out_ready[2] = 1;
    #1 chk(int'(wr_strobe), 0, "R10 collision drop");
    @(posedge clk); #1 in_valid = 0; out_ready[2] = 0;
    for (int i = 1; i < 16; i++) pop(2, 8'h20 + i, "R10 remaining order");
    @(negedge clk);
    chk(int'(out_valid[2]), 0, "R8 ch2 drained");
    chk(int'(overflow[2]), 1, "R8 flag sticky");

    do_reset();
    @(negedge clk);
    chk(int'(overflow), 0, "R1 overflow cleared by reset");
    put(8'h66, 1, "R1 channel 0 after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule